// File: doc/BRIEF.md
# Flash Status Register and Write-Protection Gate

This block keeps the status byte of a serial NOR flash and decides, one command at a time, whether a modifying instruction may run. A front end that has already shifted in and decoded an instruction presents it as a 4-bit operation code, a target byte address and, for a status write, a data byte. On the next clock edge the block raises exactly one of two flags: accept or reject. It also updates its state at that edge. An internal write timer is assumed to start on every accepted program, erase or status write, and it reports completion with a one-cycle done pulse.

Four guards act on every write path together. These are the write enable latch, the block-protect code, the status-protect bit combined with the write-protect pin, and deep power-down. The protected region grows by doubling from one end of the array. Parameters choose the end (top or bottom) and the base unit (a 64 KB block or a 4 KB sector). The non-volatile bits are plain registers that clear on reset.

Top module: `flash_wprot_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, deep power-down is off, and both accept and reject are low.
- R2: Status bit 0 (busy) goes to 1 on the edge that accepts a status write (op 4), program (op 5), sector erase (op 6), 32 KB block erase (op 7), 64 KB block erase (op 8) or chip erase (op 9). A done pulse while busy clears both bit 0 and bit 1 (write enable).
- R3: Write enable (op 1) sets status bit 1. Ops 4 to 9 are rejected while bit 1 is 0.
- R4: A rejected op 4 to 9 issued while the block is neither busy nor powered down clears status bit 1. Write disable (op 2) also clears bit 1.
- R5: Protection code p = status bits 4..2. With the default parameters (512 KB array, 64 KB unit, top end), p = 0 protects nothing, p = 7 protects the whole array, and 1 ≤ p ≤ 6 protects the top min(64 KB·2^(p−1), 512 KB). Ops 5 to 8 are rejected when the addressed byte, 4 KB sector, 32 KB block or 64 KB block overlaps that region.
- R6: Chip erase (op 9) is rejected whenever p is nonzero.
- R7: When status bit 7 is 1 and the write-protect pin is low, a status write is rejected and bits 7 and 4..2 keep their values. With the pin high, the write loads bit 7 and bits 4..2 from the same positions of the data byte.
- R8: Status bits 6 and 5 always read 0.
- R9: Op 10 enters deep power-down. While powered down, every op except release (op 11) is rejected and leaves the status byte unchanged. Op 11 leaves power-down.
- R10: While busy, every op except status read (op 3) is rejected and changes no state.
- R11: A command presented in the same cycle as the done pulse is judged against the busy state. When that command is not op 3, it is rejected and busy clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 4 | Operation code (0 none, 1 write enable, 2 write disable, 3 status read, 4 status write, 5 program, 6 sector erase, 7 32 KB erase, 8 64 KB erase, 9 chip erase, 10 power down, 11 release) |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_wdata | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | One-cycle pulse from the write timer when an operation ends |
| status_o | output | 8 | Status byte |
| cmd_accept | output | 1 | Previous-cycle command was executed |
| cmd_reject | output | 1 | Previous-cycle command was refused or ignored |
| deep_pd | output | 1 | Deep power-down is active |

## Verification
Completion of the write timer and the arrival of a new command can fall in the same cycle. The bench starts a program, then drives the done pulse and a power-down request on the same clock edge. It expects a reject, busy and write enable cleared, and power-down still off. The sweep covers every protection code against program and erase at both edges of each 32 KB block. Each outcome is compared with a region size computed arithmetically in the bench.

// File: rtl/flash_wprot_pkg.sv
// Shared operation codes and status bit positions for the flash
// write-protection block. Assumes a 4-bit decoded operation code.
package flash_wprot_pkg;

    typedef enum logic [3:0] {
        OP_NONE    = 4'd0,
        OP_WREN    = 4'd1,
        OP_WRDI    = 4'd2,
        OP_RDSR    = 4'd3,
        OP_WRSR    = 4'd4,
        OP_PROG    = 4'd5,
        OP_SEC_ER  = 4'd6,
        OP_B32_ER  = 4'd7,
        OP_B64_ER  = 4'd8,
        OP_CHIP_ER = 4'd9,
        OP_SLEEP   = 4'd10,
        OP_WAKE    = 4'd11
    } flash_op_e;

    localparam int ST_BUSY   = 0;
    localparam int ST_WEN    = 1;
    localparam int ST_PROT_L = 2;
    localparam int ST_PROT_H = 4;
    localparam int ST_LOCK   = 7;

    localparam int SECTOR_LOG2 = 12;
    localparam int B32_LOG2    = 15;
    localparam int B64_LOG2    = 16;

    // True for every operation that needs the write enable latch.
    function automatic logic needs_wen(flash_op_e op);
        return (op == OP_WRSR) || (op == OP_PROG) || (op == OP_SEC_ER) ||
               (op == OP_B32_ER) || (op == OP_B64_ER) || (op == OP_CHIP_ER);
    endfunction

endpackage

// File: rtl/flash_prot_region.sv
// Decides whether the span touched by a program or erase overlaps the
// region selected by the protection code. Assumes ADDR_W >= 17 and a
// unit size that is a power of two no smaller than a sector.
module flash_prot_region
    import flash_wprot_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int UNIT_LOG2 = 16,
    parameter bit FROM_TOP  = 1'b1
) (
    input  logic [2:0]        prot_code,
    input  flash_op_e         op,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int SIZE_W = ADDR_W + 1;
    localparam logic [SIZE_W-1:0] ARRAY_BYTES = SIZE_W'(1) << ADDR_W;

    logic [ADDR_W-1:0] span_mask;
    logic [SIZE_W-1:0] lo_addr;
    logic [SIZE_W-1:0] hi_addr;
    logic [SIZE_W-1:0] prot_bytes;
    int                span_log2;
    int                prot_log2;

    // Span covered by the operation, aligned to its own size.
    always_comb begin
        case (op)
            OP_SEC_ER: span_log2 = SECTOR_LOG2;
            OP_B32_ER: span_log2 = B32_LOG2;
            OP_B64_ER: span_log2 = B64_LOG2;
            default:   span_log2 = 0;
        endcase
        span_mask = (ADDR_W'(1) << span_log2) - ADDR_W'(1);
        lo_addr   = {1'b0, addr & ~span_mask};
        hi_addr   = {1'b0, addr | span_mask};
    end

    // Protected size doubles with each code step; the top code takes all.
    always_comb begin
        prot_log2 = UNIT_LOG2 + int'(prot_code) - 1;
        if (prot_code == 3'd0)
            prot_bytes = '0;
        else if (prot_code == 3'd7 || prot_log2 >= ADDR_W)
            prot_bytes = ARRAY_BYTES;
        else
            prot_bytes = SIZE_W'(1) << prot_log2;
    end

    generate
        if (FROM_TOP) begin : g_top
            // Region is [ARRAY - size, ARRAY): overlap when span end reaches it.
            always_comb hit = (prot_bytes != '0) && (hi_addr >= ARRAY_BYTES - prot_bytes);
        end else begin : g_bottom
            // Region is [0, size): overlap when span start lies below its end.
            always_comb hit = (lo_addr < prot_bytes);
        end
    endgenerate

endmodule

// File: rtl/flash_cmd_judge.sv
// Combinational verdict on one decoded command: accept, or reject and
// whether the rejection must drop the write enable latch.
module flash_cmd_judge
    import flash_wprot_pkg::*;
(
    input  logic      valid,
    input  flash_op_e op,
    input  logic      busy,
    input  logic      wen,
    input  logic      lock,
    input  logic      wp_n,
    input  logic      asleep,
    input  logic [2:0] prot_code,
    input  logic      region_hit,
    output logic      accept,
    output logic      reject,
    output logic      wen_drop
);
    // Guard priority: power-down, then busy, then per-op rules.
    always_comb begin
        accept = 1'b0;
        if (!valid)
            accept = 1'b0;
        else if (asleep)
            accept = (op == OP_WAKE);
        else if (busy)
            accept = (op == OP_RDSR);
        else begin
            case (op)
                OP_WREN, OP_WRDI, OP_RDSR, OP_SLEEP, OP_WAKE:
                    accept = 1'b1;
                OP_WRSR:
                    accept = wen && !(lock && !wp_n);
                OP_PROG, OP_SEC_ER, OP_B32_ER, OP_B64_ER:
                    accept = wen && !region_hit;
                OP_CHIP_ER:
                    accept = wen && (prot_code == 3'd0);
                default:
                    accept = 1'b0;
            endcase
        end
    end

    // Rejections of write-class ops in the idle state drop the latch.
    always_comb begin
        reject   = valid && !accept;
        wen_drop = reject && !asleep && !busy && needs_wen(op);
    end

endmodule

// File: rtl/flash_status_regs.sv
// Holds the status bits and the power-down flag and applies the verdict
// of the judge. The lock and protection bits stand in for non-volatile
// cells and clear on reset.
module flash_status_regs
    import flash_wprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid,
    input  flash_op_e  op,
    input  logic [7:0] wdata,
    input  logic       wp_n,
    input  logic       op_done,
    input  logic       accept,
    input  logic       reject,
    input  logic       wen_drop,
    output logic       busy_q,
    output logic       wen_q,
    output logic       lock_q,
    output logic [2:0] prot_q,
    output logic       asleep_q,
    output logic       accept_q,
    output logic       reject_q
);
    // State update: completion first, then the accepted command, then drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            wen_q    <= 1'b0;
            lock_q   <= 1'b0;
            prot_q   <= 3'd0;
            asleep_q <= 1'b0;
            accept_q <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            accept_q <= accept;
            reject_q <= reject;
            if (op_done && busy_q) begin
                busy_q <= 1'b0;
                wen_q  <= 1'b0;
            end
            if (accept) begin
                case (op)
                    OP_WREN:  wen_q <= 1'b1;
                    OP_WRDI:  wen_q <= 1'b0;
                    OP_WRSR: begin
                        prot_q <= wdata[ST_PROT_H:ST_PROT_L];
                        lock_q <= wdata[ST_LOCK];
                        busy_q <= 1'b1;
                    end
                    OP_PROG, OP_SEC_ER, OP_B32_ER, OP_B64_ER, OP_CHIP_ER:
                        busy_q <= 1'b1;
                    OP_SLEEP: asleep_q <= 1'b1;
                    OP_WAKE:  asleep_q <= 1'b0;
                    default:  ;
                endcase
            end
            if (wen_drop)
                wen_q <= 1'b0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy_q && !wen_q && !lock_q && prot_q == 3'd0 && !asleep_q));

    // R2
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && busy_q) |=> (!busy_q && !wen_q));

    // R3
    wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && needs_wen(op) && !wen_q) |=> !accept_q);

    // R7
    locked_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_WRSR && lock_q && !wp_n) |=> (lock_q && $stable(prot_q) && reject_q));

    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_q && valid && op != OP_WAKE) |=> (asleep_q && reject_q && $stable(prot_q) && $stable(wen_q)));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && valid && op != OP_RDSR) |=> (reject_q && $stable(prot_q) && $stable(lock_q)));

    // R1
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_q && reject_q));

endmodule

// File: rtl/flash_wprot_ctrl.sv
// Top of the flash status and write-protection block. Takes decoded
// commands one at a time and reports a registered verdict one cycle later.
// Assumes an external timer pulses op_done once per accepted write.
module flash_wprot_ctrl
    import flash_wprot_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int UNIT_LOG2 = 16,
    parameter bit FROM_TOP  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    input  logic              wp_n,
    input  logic              op_done,
    output logic [7:0]        status_o,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              deep_pd
);
    flash_op_e  op;
    logic       region_hit;
    logic       accept, reject, wen_drop;
    logic       busy_q, wen_q, lock_q, asleep_q;
    logic [2:0] prot_q;

    // Cast the raw code to the shared operation type.
    always_comb op = flash_op_e'(cmd_op);

    flash_prot_region #(
        .ADDR_W   (ADDR_W),
        .UNIT_LOG2(UNIT_LOG2),
        .FROM_TOP (FROM_TOP)
    ) region_i (
        .prot_code(prot_q),
        .op       (op),
        .addr     (cmd_addr),
        .hit      (region_hit)
    );

    flash_cmd_judge judge_i (
        .valid     (cmd_valid),
        .op        (op),
        .busy      (busy_q),
        .wen       (wen_q),
        .lock      (lock_q),
        .wp_n      (wp_n),
        .asleep    (asleep_q),
        .prot_code (prot_q),
        .region_hit(region_hit),
        .accept    (accept),
        .reject    (reject),
        .wen_drop  (wen_drop)
    );

    flash_status_regs regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (cmd_valid),
        .op      (op),
        .wdata   (cmd_wdata),
        .wp_n    (wp_n),
        .op_done (op_done),
        .accept  (accept),
        .reject  (reject),
        .wen_drop(wen_drop),
        .busy_q  (busy_q),
        .wen_q   (wen_q),
        .lock_q  (lock_q),
        .prot_q  (prot_q),
        .asleep_q(asleep_q),
        .accept_q(cmd_accept),
        .reject_q(cmd_reject)
    );

    // Assemble the status byte; unlisted positions read zero.
    always_comb begin
        status_o                       = 8'h00;
        status_o[ST_BUSY]              = busy_q;
        status_o[ST_WEN]               = wen_q;
        status_o[ST_PROT_H:ST_PROT_L]  = prot_q;
        status_o[ST_LOCK]              = lock_q;
        deep_pd                        = asleep_q;
    end

    // R8
    spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd4) |=> (status_o[6:5] == 2'b00));

    // R6
    chip_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd9 && status_o[4:2] != 3'd0) |=> cmd_reject);

endmodule

// File: tb/flash_wprot_ctrl_tb.sv
// Sweep bench for the flash write-protection block at default parameters.
module flash_wprot_ctrl_tb_top;
    localparam int ADDR_W = 19;
    localparam int ARRAY  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_op = 4'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_wdata = 8'h00;
    logic              wp_n = 1'b1;
    logic              op_done = 1'b0;
    logic [7:0]        status_o;
    logic              cmd_accept, cmd_reject, deep_pd;

    int n_checks = 0;
    int n_fail   = 0;
    bit ended    = 1'b0;

    always #10 clk = ~clk;

    flash_wprot_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
        .op_done(op_done), .status_o(status_o), .cmd_accept(cmd_accept),
        .cmd_reject(cmd_reject), .deep_pd(deep_pd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one command for a cycle; return after the registered verdict.
    task automatic issue(input int op, input int addr, input int data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 4'(op);
        cmd_addr  = ADDR_W'(addr);
        cmd_wdata = 8'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_op();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic set_prot(input int code, input int lock);
        issue(1, 0, 0);
        issue(4, 0, (lock << 7) | (code << 2));
        finish_op();
    endtask

    function automatic int prot_size(input int code);
        int s;
        if (code == 0) return 0;
        if (code == 7) return ARRAY;
        s = 65536 << (code - 1);
        return (s > ARRAY) ? ARRAY : s;
    endfunction

    function automatic bit exp_hit(input int code, input int op, input int addr);
        int span, lo, hi;
        span = (op == 6) ? 4096 : (op == 7) ? 32768 : (op == 8) ? 65536 : 1;
        lo = addr & ~(span - 1);
        hi = lo + span - 1;
        return (prot_size(code) != 0) && (hi >= ARRAY - prot_size(code));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(status_o == 8'h00 && !deep_pd && !cmd_accept && !cmd_reject,
              "R1", {deep_pd, cmd_accept, cmd_reject, status_o}, 0);
        rst_n = 1'b1;

        // R3: program without write enable
        issue(5, 0, 0);
        check(cmd_reject && status_o[0] == 1'b0, "R3", status_o, 0);
        issue(1, 0, 0);
        check(cmd_accept && status_o[1], "R3", status_o, 8'h02);
        // R4: write disable clears the latch
        issue(2, 0, 0);
        check(status_o[1] == 1'b0, "R4", status_o, 0);

        // R2: busy set by accepted program and cleared with latch by done
        issue(1, 0, 0);
        issue(5, 16, 0);
        check(cmd_accept && status_o[1:0] == 2'b11, "R2", status_o, 3);
        // R10: non-read ops ignored while busy; status read accepted
        issue(2, 0, 0);
        check(cmd_reject && status_o[1:0] == 2'b11, "R10", status_o, 3);
        issue(10, 0, 0);
        check(cmd_reject && !deep_pd, "R10", deep_pd, 0);
        issue(3, 0, 0);
        check(cmd_accept, "R10", cmd_accept, 1);
        finish_op();
        check(status_o[1:0] == 2'b00, "R2", status_o, 0);

        // R8: spare bits stay zero after a write with them set
        issue(1, 0, 0);
        issue(4, 0, 8'h60);
        check(cmd_accept && status_o[6:5] == 2'b00, "R8", status_o, 1);
        finish_op();

        // R5 / R6 / R4: sweep every protection code
        for (int code = 0; code < 8; code++) begin
            set_prot(code, 0);
            check(status_o == 8'(code << 2), "R5", status_o, code << 2);
            for (int op = 5; op <= 8; op++) begin
                for (int k = 0; k < 16; k++) begin
                    for (int e = 0; e < 2; e++) begin
                        int a;
                        bit h;
                        a = k * 32768 + (e ? 32767 : 0);
                        h = exp_hit(code, op, a);
                        issue(1, 0, 0);
                        issue(op, a, 0);
                        check(cmd_accept == !h && cmd_reject == h, "R5", cmd_accept, !h);
                        if (h) check(status_o[1] == 1'b0, "R4", status_o, code << 2);
                        else finish_op();
                    end
                end
            end
            issue(1, 0, 0);
            issue(9, 0, 0);
            check(cmd_accept == (code == 0), "R6", cmd_accept, code == 0);
            if (code == 0) finish_op();
        end

        // R7: lock with pin low blocks status writes; pin high allows them
        set_prot(2, 1);
        check(status_o == 8'h88, "R7", status_o, 8'h88);
        wp_n = 1'b0;
        issue(1, 0, 0);
        issue(4, 0, 8'h00);
        check(cmd_reject && status_o == 8'h88, "R7", status_o, 8'h88);
        wp_n = 1'b1;
        issue(1, 0, 0);
        issue(4, 0, 8'h00);
        check(cmd_accept && status_o == 8'h03, "R7", status_o, 8'h03);
        finish_op();

        // R9: deep power-down ignores all but release
        issue(10, 0, 0);
        check(cmd_accept && deep_pd, "R9", deep_pd, 1);
        issue(1, 0, 0);
        check(cmd_reject && status_o == 8'h00, "R9", status_o, 0);
        issue(3, 0, 0);
        check(cmd_reject && deep_pd, "R9", deep_pd, 1);
        issue(11, 0, 0);
        check(cmd_accept && !deep_pd, "R9", deep_pd, 0);

        // R11: done pulse and command on the same edge
        issue(1, 0, 0);
        issue(5, 0, 0);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 4'd10;
        op_done   = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        op_done   = 1'b0;
        check(cmd_reject && !deep_pd && status_o[1:0] == 2'b00, "R11",
              {deep_pd, status_o}, 0);

        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule